// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 16-bit successive-approximation converter. A falling edge on the active-low start input, taken while the block is idle and not powered down, moves it out of acquisition and into a conversion. The conversion is a binary search over the code space, most significant bit first. For each trial the block puts a trial code on `dac_o`. A comparator outside the block (a behavioural model in the bench) answers on `cmp_i` whether the held input is at or above that trial. When the last bit is decided, the block latches the result in the coding chosen by `straight_i`, lowers `busy_o` and raises a one-cycle valid strobe.

The block has three speed/power modes, and the number of system-clock cycles per bit decision is a parameter for each mode. After every conversion the block waits for an acquisition time, also counted in cycles. In the low-power mode the block starts the next conversion by itself if the start input is still low at the end of acquisition. A running conversion cannot be stopped by a new start edge or by power-down. Only reset stops it. In the fast mode, the accuracy of a result is flagged as not guaranteed when the previous conversion start lies more than a parameterised number of cycles back.

The result leaves the block as a stream with a valid strobe and no ready. The converter cannot stall, so the sink must take each result in the cycle `res_vld_o` is high. A result that is not taken is replaced by the next one.

Top module: `sar_conv_seq`

## Requirements
- R1: When the block is idle, `pd_i` is low and `start_n_i` is sampled low one cycle after it was sampled high, `busy_o` is high from the next cycle.
- R2: While a conversion runs, further falling edges on `start_n_i` and a high `pd_i` neither restart nor shorten it. `busy_o` stays high for the full conversion and the result is unchanged. A high `rst` ends it at once, with no result strobe.
- R3: While `pd_i` is high, no new conversion starts, whether from an edge or from the low-power self-restart.
- R4: A conversion makes 16 decisions, MSB first. Each decision takes STEP cycles of the active mode, so `busy_o` stays high for exactly 16×STEP cycles.
- R5: In the low-power mode only, a start input still low when the ACQ_CYC-cycle acquisition ends starts a new conversion, so `busy_o` is low for exactly ACQ_CYC cycles between the two. In the other modes a start input held low starts nothing more.
- R6: With `straight_i` high the result is the plain binary code. With `straight_i` low, bit 15 is inverted, which gives two's complement.
- R7: In the fast mode, `res_good_o` is 0 for a conversion that is the first since reset, or that starts more than STALE_LIM cycles after the previous start. Otherwise it is 1. Results of the other modes always have `res_good_o` = 1.
- R8: The mode is fast when `fast_sel_i`=1 and `lowp_sel_i`=0, low-power when `lowp_sel_i`=1 and `fast_sel_i`=0, and normal in every other case (both low or both high).
- R9: `res_data_o` and `res_good_o` update in the cycle `busy_o` falls. `res_vld_o` is high for exactly that one cycle, with no back-pressure.
- R10: After reset, `busy_o`, `res_vld_o` and `res_good_o` are 0 and `res_data_o` is 0.
- R11: With a comparator that answers 1 when the held code is greater than or equal to the trial code, the straight-binary result equals the held code, including 0x0000, 0x8000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high; aborts a conversion |
| start_n_i | input | 1 | Conversion start, falling edge active |
| pd_i | input | 1 | Power-down; blocks new conversions |
| fast_sel_i | input | 1 | Fast mode select |
| lowp_sel_i | input | 1 | Low-power mode select |
| straight_i | input | 1 | 1 = straight binary, 0 = two's complement |
| cmp_i | input | 1 | Comparator decision: 1 = input at or above trial code |
| dac_o | output | 16 | Trial code under test |
| busy_o | output | 1 | Conversion in progress |
| res_data_o | output | 16 | Latched result |
| res_vld_o | output | 1 | One-cycle result strobe |
| res_good_o | output | 1 | Accuracy-guaranteed flag for the latched result |

## Verification
The bench builds the block with 2, 3 and 4 cycles per decision for the fast, normal and low-power modes. This gives busy widths of 32, 48 and 64 cycles, so an exact width check tells the modes apart. The acquisition time is 5 cycles, which makes the low-power self-restart gap short enough to count exactly. The stale limit is 200 cycles, so both a back-to-back fast conversion and one after a 300-cycle pause fit in a short run and fall on either side of the accuracy rule.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    MODE_NORM = 2'd0,
    MODE_FAST = 2'd1,
    MODE_LOWP = 2'd2
  } sar_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_ACQ  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_mode_sel.sv
module sar_mode_sel
  import sar_seq_pkg::*;
#(
  parameter int STEP_FAST = 5,
  parameter int STEP_NORM = 6,
  parameter int STEP_LOWP = 8,
  parameter int SW        = 4
) (
  input  logic          fast_sel_i,
  input  logic          lowp_sel_i,
  output sar_mode_e     mode_o,
  output logic [SW-1:0] step_o
);
  always_comb begin
    if (fast_sel_i && !lowp_sel_i)      mode_o = MODE_FAST;
    else if (lowp_sel_i && !fast_sel_i) mode_o = MODE_LOWP;
    else                                mode_o = MODE_NORM;
  end

  always_comb begin
    case (mode_o)
      MODE_FAST: step_o = SW'(STEP_FAST);
      MODE_LOWP: step_o = SW'(STEP_LOWP);
      default:   step_o = SW'(STEP_NORM);
    endcase
  end
endmodule

// File: rtl/sar_stale_mon.sv
module sar_stale_mon #(
  parameter int LIM = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic long_o
);
  localparam int CW = $clog2(LIM + 2);

  logic [CW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (go_i) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap <= CW'(LIM)) begin
      gap <= gap + 1'b1;
    end
  end

  assign long_o = !seen || (gap > CW'(LIM));

  // R7
  gap_sat_chk: assert property (@(posedge clk) disable iff (rst)
    gap <= CW'(LIM + 1));
endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine #(
  parameter int W  = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [SW-1:0] step_i,
  input  logic          cmp_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [W-1:0]  code_o,
  output logic [W-1:0]  final_o
);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [IW-1:0] idx;
  logic [SW-1:0] stepc, lim;
  logic [W-1:0]  code, decided, nxt;
  logic          busy, last_tick;

  assign last_tick = busy && (stepc == lim - 1'b1);

  always_comb begin
    decided = code;
    if (!cmp_i) decided[idx] = 1'b0;
    nxt = decided;
    if (idx != '0) nxt[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy  <= 1'b0;
      code  <= '0;
      idx   <= IW'(W - 1);
      stepc <= '0;
      lim   <= SW'(1);
    end else if (!busy) begin
      if (go_i) begin
        busy  <= 1'b1;
        code  <= MSB_ONLY;
        idx   <= IW'(W - 1);
        stepc <= '0;
        lim   <= step_i;
      end
    end else if (last_tick) begin
      code  <= nxt;
      stepc <= '0;
      if (idx == '0) busy <= 1'b0;
      else           idx  <= idx - 1'b1;
    end else begin
      stepc <= stepc + 1'b1;
    end
  end

  assign busy_o  = busy;
  assign fin_o   = last_tick && (idx == '0);
  assign code_o  = code;
  assign final_o = decided;

  // R2
  no_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !fin_o) |=> busy);
  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (code == MSB_ONLY));
  // R4
  one_trial_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_tick) |=> $stable(code));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int W         = 16,
  parameter int STEP_FAST = 5,
  parameter int STEP_NORM = 6,
  parameter int STEP_LOWP = 8,
  parameter int ACQ_CYC   = 100,
  parameter int STALE_LIM = 100000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n_i,
  input  logic         pd_i,
  input  logic         fast_sel_i,
  input  logic         lowp_sel_i,
  input  logic         straight_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic         busy_o,
  output logic [W-1:0] res_data_o,
  output logic         res_vld_o,
  output logic         res_good_o
);
  localparam int SMAX = (STEP_FAST > STEP_NORM)
                        ? ((STEP_FAST > STEP_LOWP) ? STEP_FAST : STEP_LOWP)
                        : ((STEP_NORM > STEP_LOWP) ? STEP_NORM : STEP_LOWP);
  localparam int SW = $clog2(SMAX + 1);
  localparam int AW = $clog2(ACQ_CYC + 1);

  sar_mode_e     mode;
  logic [SW-1:0] step;
  sar_state_e    st;
  logic [AW-1:0] acq_cnt;
  logic          start_q, start_fall, acq_end, go, gap_long, good_lat;
  logic          eng_busy, eng_fin;
  logic [W-1:0]  eng_final, coded;

  sar_mode_sel #(
    .STEP_FAST(STEP_FAST), .STEP_NORM(STEP_NORM),
    .STEP_LOWP(STEP_LOWP), .SW(SW)
  ) mode_i (
    .fast_sel_i(fast_sel_i), .lowp_sel_i(lowp_sel_i),
    .mode_o(mode), .step_o(step)
  );

  sar_stale_mon #(.LIM(STALE_LIM)) stale_i (
    .clk(clk), .rst(rst), .go_i(go), .long_o(gap_long)
  );

  sar_bit_engine #(.W(W), .SW(SW)) eng_i (
    .clk(clk), .rst(rst), .go_i(go), .step_i(step), .cmp_i(cmp_i),
    .busy_o(eng_busy), .fin_o(eng_fin), .code_o(dac_o), .final_o(eng_final)
  );

  assign start_fall = start_q && !start_n_i;
  assign acq_end    = (st == ST_ACQ) && (acq_cnt == AW'(ACQ_CYC - 1));
  assign go = !pd_i && (((st == ST_IDLE) && start_fall) ||
                        (acq_end && (mode == MODE_LOWP) && !start_n_i));
  assign coded = straight_i ? eng_final : {~eng_final[W-1], eng_final[W-2:0]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      start_q    <= 1'b1;
      st         <= ST_IDLE;
      acq_cnt    <= '0;
      good_lat   <= 1'b0;
      res_data_o <= '0;
      res_vld_o  <= 1'b0;
      res_good_o <= 1'b0;
    end else begin
      start_q   <= start_n_i;
      res_vld_o <= 1'b0;
      if (go) begin
        st       <= ST_CONV;
        good_lat <= !((mode == MODE_FAST) && gap_long);
      end else begin
        case (st)
          ST_CONV: if (eng_fin) begin
            st         <= ST_ACQ;
            acq_cnt    <= '0;
            res_data_o <= coded;
            res_good_o <= good_lat;
            res_vld_o  <= 1'b1;
          end
          ST_ACQ: begin
            if (acq_end) st <= ST_IDLE;
            else         acq_cnt <= acq_cnt + 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = eng_busy;

  // R1
  start_go_chk: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && start_fall && !pd_i) |=> busy_o);
  // R3
  pd_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && pd_i) |=> !busy_o);
  // R9
  vld_busy_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld_o |-> (!busy_o && $past(busy_o)));
  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    res_vld_o |=> !res_vld_o);
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb_top;
  localparam int SF = 2, SN = 3, SL = 4, ACQ = 5, LIM = 200;

  typedef struct packed { logic [15:0] data; logic good; } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic start_n = 1'b1, pd = 1'b0, fsel = 1'b0, lsel = 1'b0, sb = 1'b1;
  logic [15:0] ain = '0;
  logic cmp;
  logic [15:0] dac, res;
  logic busy, vld, good;
  int ntot = 0, nfail = 0;
  exp_t q[$];

  always #5 clk = ~clk;
  assign cmp = (ain >= dac);

  sar_conv_seq #(.W(16), .STEP_FAST(SF), .STEP_NORM(SN), .STEP_LOWP(SL),
                 .ACQ_CYC(ACQ), .STALE_LIM(LIM)) dut_i (
    .clk(clk), .rst(rst), .start_n_i(start_n), .pd_i(pd),
    .fast_sel_i(fsel), .lowp_sel_i(lsel), .straight_i(sb), .cmp_i(cmp),
    .dac_o(dac), .busy_o(busy), .res_data_o(res), .res_vld_o(vld),
    .res_good_o(good));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: R9 R6 R7 R11
  always @(negedge clk) begin
    if (!rst && vld) begin
      if (q.size() == 0) chk(1'b0, "R9 unexpected result strobe", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(res == e.data, "R11/R6 result data", res, e.data);
        chk(good == e.good, "R7 good flag", good, e.good);
        chk(!busy, "R9 busy low with strobe", busy, 0);
      end
    end
  end

  function automatic logic [15:0] enc(input logic [15:0] a, input logic s);
    return s ? a : {~a[15], a[14:0]};
  endfunction

  // one conversion; width of busy checked (R4), optional retrigger / pd mid-run (R2)
  task automatic conv(input logic f, input logic l, input logic [15:0] a,
                      input logic s, input logic eg, input int ew,
                      input logic retrig, input logic pdmid, input string tag);
    int n;
    @(negedge clk);
    fsel = f; lsel = l; ain = a; sb = s;
    q.push_back('{data: enc(a, s), good: eg});
    @(negedge clk);
    start_n = 1'b0;
    @(negedge clk);
    chk(busy, {tag, " R1 busy rises"}, busy, 1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 6 && retrig) start_n = 1'b1;
      if (n == 8 && retrig) start_n = 1'b0;
      if (n == 9 && pdmid) pd = 1'b1;
      @(negedge clk);
    end
    chk(n == ew, {tag, " R4 busy width"}, n, ew);
    start_n = 1'b1;
    repeat (ACQ + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !vld && !good && res == 0, "R10 reset state", {busy, vld, good}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R7: first fast conversion after reset is flagged; back-to-back is fine
    conv(1, 0, 16'h1234, 1, 0, 16*SF, 0, 0, "R7 first fast");
    conv(1, 0, 16'h4321, 1, 1, 16*SF, 0, 0, "R7 fast again");
    repeat (300) @(negedge clk);
    conv(1, 0, 16'h0F0F, 1, 0, 16*SF, 0, 0, "R7 fast after gap");
    repeat (300) @(negedge clk);
    conv(0, 0, 16'h0F0F, 1, 1, 16*SN, 0, 0, "R7 normal after gap");
    // R11 boundaries, R6 coding
    conv(0, 0, 16'h0000, 1, 1, 16*SN, 0, 0, "R11 zero");
    conv(0, 0, 16'hFFFF, 1, 1, 16*SN, 0, 0, "R11 full");
    conv(0, 0, 16'h8000, 1, 1, 16*SN, 0, 0, "R11 mid");
    conv(0, 0, 16'hA5A5, 0, 1, 16*SN, 0, 0, "R6 twos comp");
    conv(0, 0, 16'h7FFF, 0, 1, 16*SN, 0, 0, "R6 twos comp low");
    // R8 mode decode
    conv(1, 1, 16'h5555, 1, 1, 16*SN, 0, 0, "R8 both selects");
    conv(0, 1, 16'h3C3C, 1, 1, 16*SL, 0, 0, "R8 low power");
    // R2 retrigger and power-down mid-run; R3 completes then blocks
    conv(0, 0, 16'hC001, 1, 1, 16*SN, 1, 1, "R2 retrig and pd");
    begin
      int rose = 0;
      start_n = 1'b0;
      repeat (40) begin @(negedge clk); if (busy) rose = 1; end
      chk(rose == 0, "R3 pd blocks start", rose, 0);
      start_n = 1'b1; pd = 1'b0;
      repeat (3) @(negedge clk);
    end
    // R5 low-power self restart
    begin
      int gap = 0;
      fsel = 0; lsel = 1; ain = 16'h2468; sb = 1;
      q.push_back('{data: 16'h2468, good: 1'b1});
      q.push_back('{data: 16'h2468, good: 1'b1});
      @(negedge clk); start_n = 1'b0;
      while (!busy) @(negedge clk);
      while (busy) @(negedge clk);
      while (!busy && gap < 100) begin gap++; @(negedge clk); end
      chk(gap == ACQ, "R5 restart gap", gap, ACQ);
      start_n = 1'b1;
      while (busy) @(negedge clk);
      gap = 0;
      repeat (30) begin @(negedge clk); if (busy) gap = 1; end
      chk(gap == 0, "R5 stops when start high", gap, 0);
    end
    // R5 no self restart in normal mode
    begin
      int again = 0;
      lsel = 0; ain = 16'h1111;
      q.push_back('{data: 16'h1111, good: 1'b1});
      @(negedge clk); start_n = 1'b0;
      while (!busy) @(negedge clk);
      while (busy) @(negedge clk);
      repeat (ACQ + 20) begin @(negedge clk); if (busy) again = 1; end
      chk(again == 0, "R5 normal mode no restart", again, 0);
      start_n = 1'b1;
      repeat (3) @(negedge clk);
    end
    // R2 reset aborts
    ain = 16'h9999;
    @(negedge clk); start_n = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && res == 0 && !good, "R2 reset aborts", {busy, good}, 0);
    rst = 1'b0; start_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R9 all results seen", q.size(), 0);
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    ntot++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule